// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is the register bank behind the move-to-coprocessor and move-from-coprocessor accesses of a small 32-bit CPU's system-control coprocessor. Each access presents a register index, an operation code and, for a write, a data word. Whether an access is legal depends on the index and the op code together. The bank holds four software-visible storage words: system control, page-table base, data fault status and fault address. It also returns two constant words, a CPU identification word and a cache-type word, which are set by parameters.

Two further indices do not store anything. Writes to them are decoded into one-cycle command pulses. One group of pulses drives cache maintenance: whole-cache invalidate, clean and flush, plus per-line operations that carry an address. The other pulse requests that the whole TLB be invalidated. The block only decodes these requests. The caches and the TLB that act on them live elsewhere. Any access the block does not recognise returns zero data, if it is a read, and raises a one-cycle error flag that the core can trap on.

Top module: `sysctl_coproc`

## Requirements
- R1: While `rst_n` is low and after it is released, all four storage words read as zero and `cache_cmd`, `tlb_inv_all` and `acc_err` are low.
- R2: Index 0 is constant. A read with op 0 returns parameter `CPU_ID` and a read with op 1 returns parameter `CACHE_TYPE`. Any write to index 0 is unrecognised and changes nothing.
- R3: Indices 1, 2, 3 and 4 are system control, page-table base, data fault status and fault address. With op 0 a write stores `acc_wdata` at the clock edge, and a read returns the stored word combinationally.
- R4: A read or write of indices 1 to 4 with a non-zero op is unrecognised. It changes no stored word and returns zero data.
- R5: A write to index 5 decodes whole-cache commands onto `cache_cmd` bits: op 28 gives bit 0 (invalidate I and D), op 20 gives bit 1 (invalidate I), op 12 gives bit 2 (invalidate D), op 10 gives bit 3 (clean D) and op 14 gives bit 4 (flush D). Any other op at index 5 is unrecognised.
- R6: A write to index 5 with op 13, 11 or 15 gives `cache_cmd` bit 5 (invalidate D line), bit 6 (clean D line) or bit 7 (flush D line). `cache_line_addr` then shows that write's `acc_wdata` in the same cycle as the pulse.
- R7: A write to index 6 with an op from 2 to 6 inclusive pulses `tlb_inv_all`. Any other op at index 6 is unrecognised and gives no pulse.
- R8: A read of any pair not named in R2 or R3 returns zero. This covers indices 5 and 6 and every index above 6.
- R9: A write to an index above 6 changes no stored word and raises no command.
- R10: Every command pulse is high for exactly the one cycle after the clock edge that accepted the write. At most one of `cache_cmd` and `tlb_inv_all` is high in any cycle, and all of them are low after an idle cycle.
- R11: Each unrecognised access with `acc_valid` high, read or write, sets `acc_err` for the single cycle after its accepting edge. A recognised access leaves `acc_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = move to coprocessor (write), 0 = move from coprocessor (read) |
| acc_idx | input | IDX_W (4) | Register index |
| acc_op | input | OP_W (5) | Operation code qualifying the index |
| acc_wdata | input | DATA_W (32) | Write data, or line address for line commands |
| rd_data | output | DATA_W (32) | Combinational read data for `acc_idx`/`acc_op` |
| cache_cmd | output | 8 | One-hot cache maintenance pulse |
| cache_line_addr | output | DATA_W (32) | Address for the line command |
| tlb_inv_all | output | 1 | Whole-TLB invalidate pulse |
| acc_err | output | 1 | Unrecognised access pulse |

## Verification
Read data is due in the same cycle as the access, because it comes from combinational decode. The driver therefore checks `rd_data` one time step after it sets the inputs and before the next clock edge. A stored write, a command pulse and the error flag all show up in the cycle after the accepting edge. For each access the driver queues the expected pulse pattern, and a monitor pops it at the falling edge that follows that rising edge. For cycles with no access, the monitor checks that every pulse is low, so a pulse that lasts two cycles is caught. A written value is checked by a later read through the same combinational path, so a stored word is only ever observed after its write edge has passed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NCACHE_CMD = 8;
  localparam int NSTORE_REG = 4;

  // op code for each cache command bit, bit order is the output encoding
  localparam logic [7:0] CACHE_OP [NCACHE_CMD] = '{
    8'd28,  // 0 invalidate I and D
    8'd20,  // 1 invalidate I
    8'd12,  // 2 invalidate D
    8'd10,  // 3 clean D
    8'd14,  // 4 flush D
    8'd13,  // 5 invalidate D line
    8'd11,  // 6 clean D line
    8'd15   // 7 flush D line
  };

  // commands that carry a line address in the write data
  localparam logic [NCACHE_CMD-1:0] LINE_CMD_MASK = 8'b1110_0000;

  // inclusive op window of the TLB command index
  localparam int TLB_OP_LO = 2;
  localparam int TLB_OP_HI = 6;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int OP_W   = 5,
  parameter int NSTORE = NSTORE_REG,
  parameter int NCMD   = NCACHE_CMD
) (
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [OP_W-1:0]  acc_op,
  output logic             rd_id,
  output logic             rd_ctype,
  output logic [NSTORE-1:0] store_match,
  output logic [NSTORE-1:0] store_wr_en,
  output logic [NCMD-1:0]  cache_hit,
  output logic             tlb_hit,
  output logic             bad_access
);

  localparam logic [IDX_W-1:0] IX_CONST = '0;
  localparam logic [IDX_W-1:0] IX_CACHE = IDX_W'(1 + NSTORE);
  localparam logic [IDX_W-1:0] IX_TLB   = IDX_W'(2 + NSTORE);
  localparam logic [OP_W-1:0]  OP_TLO   = OP_W'(TLB_OP_LO);
  localparam logic [OP_W-1:0]  OP_THI   = OP_W'(TLB_OP_HI);

  logic             op_zero;
  logic             wr_req;
  logic [NCMD-1:0]  cache_match;
  logic             tlb_match;
  logic             wr_known;
  logic             rd_known;

  assign op_zero = (acc_op == '0);
  assign wr_req  = acc_valid & acc_write;

  genvar gs;
  generate
    for (gs = 0; gs < NSTORE; gs++) begin : g_store
      assign store_match[gs] = op_zero && (acc_idx == IDX_W'(gs + 1));
      assign store_wr_en[gs] = wr_req & store_match[gs];
    end
  endgenerate

  genvar gc;
  generate
    for (gc = 0; gc < NCMD; gc++) begin : g_cache
      assign cache_match[gc] = (acc_idx == IX_CACHE) && (acc_op == OP_W'(CACHE_OP[gc]));
      assign cache_hit[gc]   = wr_req & cache_match[gc];
    end
  endgenerate

  always_comb begin
    tlb_match = (acc_idx == IX_TLB) && (acc_op >= OP_TLO) && (acc_op <= OP_THI);
    rd_id     = (acc_idx == IX_CONST) && op_zero;
    rd_ctype  = (acc_idx == IX_CONST) && (acc_op == OP_W'(1));
    wr_known  = (|store_match) | (|cache_match) | tlb_match;
    rd_known  = rd_id | rd_ctype | (|store_match);
    tlb_hit   = wr_req & tlb_match;
    if (!acc_valid) begin
      bad_access = 1'b0;
    end else if (acc_write) begin
      bad_access = !wr_known;
    end else begin
      bad_access = !rd_known;
    end
  end

  // a bad access never also decodes a command
  always_comb begin
    assert (!(bad_access && (tlb_hit || (|cache_hit) || (|store_wr_en))))
      else $error("AST_BAD_NO_ACTION");  // R9
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int DATA_W = 32,
  parameter int NSTORE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSTORE-1:0]             wr_en,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NSTORE-1:0][DATA_W-1:0] store_q
);

  genvar g;
  generate
    for (g = 0; g < NSTORE; g++) begin : g_word
      logic [DATA_W-1:0] word_nxt;

      always_comb begin
        if (wr_en[g]) begin
          word_nxt = wdata;
        end else begin
          word_nxt = store_q[g];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          store_q[g] <= '0;
        end else begin
          store_q[g] <= word_nxt;
        end
      end

      AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[g] |=> $stable(store_q[g]))
        else $error("AST_WORD_HOLD");  // R4
    end
  endgenerate

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCMD   = NCACHE_CMD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCMD-1:0]   cache_hit,
  input  logic              tlb_hit,
  input  logic              bad_access,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCMD-1:0]   cache_cmd,
  output logic [DATA_W-1:0] line_addr,
  output logic              tlb_inv,
  output logic              err_pulse
);

  logic [NCMD-1:0]   cache_nxt;
  logic [DATA_W-1:0] line_nxt;
  logic              tlb_nxt;
  logic              err_nxt;
  logic              line_load;

  always_comb begin
    cache_nxt = cache_hit;
    tlb_nxt   = tlb_hit;
    err_nxt   = bad_access;
    line_load = |(cache_hit & LINE_CMD_MASK[NCMD-1:0]);
    if (line_load) begin
      line_nxt = wdata;
    end else begin
      line_nxt = line_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_cmd <= '0;
      tlb_inv   <= 1'b0;
      err_pulse <= 1'b0;
      line_addr <= '0;
    end else begin
      cache_cmd <= cache_nxt;
      tlb_inv   <= tlb_nxt;
      err_pulse <= err_nxt;
      line_addr <= line_nxt;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_inv && !$past(tlb_hit)) |-> 1'b0)
    else $error("AST_PULSE_ONE_CYCLE");  // R10

  AST_LINE_ADDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_hit[5] || cache_hit[6] || cache_hit[7]) |=> (line_addr == $past(wdata)))
    else $error("AST_LINE_ADDR_SET");  // R6

endmodule

// File: rtl/sysctl_coproc.sv
module sysctl_coproc
  import sysctl_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                IDX_W      = 4,
  parameter int                OP_W       = 5,
  parameter logic [DATA_W-1:0] CPU_ID     = 32'h4d43_0863,
  parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0d17_2f2a
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [OP_W-1:0]   acc_op,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCACHE_CMD-1:0] cache_cmd,
  output logic [DATA_W-1:0] cache_line_addr,
  output logic              tlb_inv_all,
  output logic              acc_err
);

  localparam int NSTORE = NSTORE_REG;
  localparam int NCMD   = NCACHE_CMD;
  localparam logic [IDX_W-1:0] IX_LAST = IDX_W'(2 + NSTORE);

  logic                          rd_id;
  logic                          rd_ctype;
  logic [NSTORE-1:0]             store_match;
  logic [NSTORE-1:0]             store_wr_en;
  logic [NCMD-1:0]               cache_hit;
  logic                          tlb_hit;
  logic                          bad_access;
  logic [NSTORE-1:0][DATA_W-1:0] store_q;

  sysctl_decode #(
    .IDX_W (IDX_W),
    .OP_W  (OP_W),
    .NSTORE(NSTORE),
    .NCMD  (NCMD)
  ) u_decode (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_idx    (acc_idx),
    .acc_op     (acc_op),
    .rd_id      (rd_id),
    .rd_ctype   (rd_ctype),
    .store_match(store_match),
    .store_wr_en(store_wr_en),
    .cache_hit  (cache_hit),
    .tlb_hit    (tlb_hit),
    .bad_access (bad_access)
  );

  sysctl_store #(
    .DATA_W(DATA_W),
    .NSTORE(NSTORE)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (store_wr_en),
    .wdata  (acc_wdata),
    .store_q(store_q)
  );

  sysctl_cmd #(
    .DATA_W(DATA_W),
    .NCMD  (NCMD)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cache_hit (cache_hit),
    .tlb_hit   (tlb_hit),
    .bad_access(bad_access),
    .wdata     (acc_wdata),
    .cache_cmd (cache_cmd),
    .line_addr (cache_line_addr),
    .tlb_inv   (tlb_inv_all),
    .err_pulse (acc_err)
  );

  // combinational read mux, zero for anything not decoded
  always_comb begin
    rd_data = '0;
    if (rd_id) begin
      rd_data = CPU_ID;
    end else if (rd_ctype) begin
      rd_data = CACHE_TYPE;
    end else begin
      for (int k = 0; k < NSTORE; k++) begin
        if (store_match[k]) begin
          rd_data = store_q[k];
        end
      end
    end
  end

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_idx == '0 && acc_op == '0) |-> (rd_data == CPU_ID))
    else $error("AST_ID_READ");  // R2

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_idx == IDX_W'(2) && acc_op == '0)
      |=> (store_q[1] == $past(acc_wdata)))
    else $error("AST_STORE_WRITE");  // R3

  AST_HIGH_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_idx > IX_LAST)
      |=> ($stable(store_q) && cache_cmd == '0 && !tlb_inv_all && acc_err))
    else $error("AST_HIGH_IDX_HOLD");  // R9

  AST_UNREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_idx > IDX_W'(NSTORE)) |-> (rd_data == '0))
    else $error("AST_UNREAD_ZERO");  // R8

  AST_TLB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_idx == IX_LAST
      && acc_op >= OP_W'(TLB_OP_LO) && acc_op <= OP_W'(TLB_OP_HI))
      |=> (tlb_inv_all && cache_cmd == '0 && !acc_err))
    else $error("AST_TLB_WINDOW");  // R7

  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cache_cmd, tlb_inv_all, acc_err}))
    else $error("AST_CMD_EXCL");  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (cache_cmd == '0 && !tlb_inv_all && !acc_err))
    else $error("AST_IDLE_QUIET");  // R11

endmodule

// File: tb/sysctl_coproc_tb.sv
module sysctl_coproc_tb;

  localparam logic [31:0] ID_W = 32'h4d43_0863;
  localparam logic [31:0] CT_W = 32'h0d17_2f2a;

  typedef struct {
    string       req;
    logic [7:0]  cc;
    logic        tlb;
    logic        err;
    logic        chk_line;
    logic [31:0] line;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [3:0]  acc_idx;
  logic [4:0]  acc_op;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic [7:0]  cache_cmd;
  logic [31:0] cache_line_addr;
  logic        tlb_inv_all;
  logic        acc_err;

  int total = 0;
  int bad = 0;
  bit done = 0;
  exp_t q[$];
  logic [31:0] mdl [1:4];
  logic [31:0] mdl_line;

  always #5 clk = ~clk;

  sysctl_coproc u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .acc_op(acc_op), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .cache_cmd(cache_cmd), .cache_line_addr(cache_line_addr),
    .tlb_inv_all(tlb_inv_all), .acc_err(acc_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int cache_bit(input int op);
    case (op)
      28: return 0;  20: return 1;  12: return 2;  10: return 3;
      14: return 4;  13: return 5;  11: return 6;  15: return 7;
      default: return -1;
    endcase
  endfunction

  // driver: applies one access, checks read data, queues pulse expectation
  task automatic access(input string req, input bit wr, input int idx,
                        input int op, input logic [31:0] d);
    exp_t e;
    logic [31:0] exp_rd;
    bit known;
    int cb;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_idx   = 4'(idx);
    acc_op    = 5'(op);
    acc_wdata = d;
    e.req = req; e.cc = '0; e.tlb = 1'b0; e.err = 1'b0; e.chk_line = 1'b0; e.line = '0;
    known = 0;
    exp_rd = '0;
    if (!wr) begin
      if (idx == 0 && op == 0) begin exp_rd = ID_W; known = 1; end
      else if (idx == 0 && op == 1) begin exp_rd = CT_W; known = 1; end
      else if (idx >= 1 && idx <= 4 && op == 0) begin exp_rd = mdl[idx]; known = 1; end
      #1;
      check(req, "rd_data", rd_data, exp_rd);
    end else begin
      cb = cache_bit(op);
      if (idx >= 1 && idx <= 4 && op == 0) begin
        mdl[idx] = d; known = 1;
      end else if (idx == 5 && cb >= 0) begin
        e.cc[cb] = 1'b1; known = 1;
        if (cb >= 5) begin mdl_line = d; e.chk_line = 1'b1; end
      end else if (idx == 6 && op >= 2 && op <= 6) begin
        e.tlb = 1'b1; known = 1;
      end
    end
    e.err = !known;
    e.line = mdl_line;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
    end
  endtask

  // monitor: compares registered pulses in the cycle after each edge
  initial begin
    bit had;
    exp_t e;
    forever begin
      @(posedge clk);
      had = acc_valid && rst_n;
      @(negedge clk);
      if (had) begin
        if (q.size() == 0) begin
          check("R10", "queue", 32'd0, 32'd1);
        end else begin
          e = q.pop_front();
          check(e.req, "cache_cmd", {24'd0, cache_cmd}, {24'd0, e.cc});
          check(e.req, "tlb_inv_all", {31'd0, tlb_inv_all}, {31'd0, e.tlb});
          check({e.req, "/R11"}, "acc_err", {31'd0, acc_err}, {31'd0, e.err});
          if (e.chk_line) check(e.req, "cache_line_addr", cache_line_addr, e.line);
        end
      end else if (rst_n) begin
        check("R10", "idle pulses", {22'd0, cache_cmd, tlb_inv_all, acc_err}, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_idx = '0; acc_op = '0; acc_wdata = '0;
    for (int i = 1; i <= 4; i++) mdl[i] = '0;
    mdl_line = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "pulses in reset", {22'd0, cache_cmd, tlb_inv_all, acc_err}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset values
    for (int i = 1; i <= 4; i++) access("R1", 0, i, 0, '0);
    // R2 constants, write ignored
    access("R2", 0, 0, 0, '0);
    access("R2", 0, 0, 1, '0);
    access("R2", 1, 0, 0, 32'hffff_ffff);
    access("R2", 0, 0, 0, '0);
    access("R2", 0, 0, 2, '0);
    // R3 storage writes then reads
    access("R3", 1, 1, 0, 32'h1111_0001);
    access("R3", 1, 2, 0, 32'h2222_0002);
    access("R3", 1, 3, 0, 32'h3333_0003);
    access("R3", 1, 4, 0, 32'h4444_0004);
    for (int i = 1; i <= 4; i++) access("R3", 0, i, 0, '0);
    access("R3", 1, 2, 0, 32'ha5a5_5a5a);
    access("R3", 0, 2, 0, '0);
    // R4 wrong op on storage
    access("R4", 1, 2, 3, 32'hdead_beef);
    access("R4", 1, 4, 31, 32'hdead_beef);
    access("R4", 0, 2, 0, '0);
    access("R4", 0, 4, 0, '0);
    access("R4", 0, 1, 1, '0);
    // R5 whole-cache commands and a bad op
    access("R5", 1, 5, 28, '0);
    access("R5", 1, 5, 20, '0);
    access("R5", 1, 5, 12, '0);
    access("R5", 1, 5, 10, '0);
    access("R5", 1, 5, 14, '0);
    access("R5", 1, 5, 0, '0);
    access("R5", 1, 5, 7, '0);
    // R6 line commands
    access("R6", 1, 5, 13, 32'h0000_1040);
    access("R6", 1, 5, 11, 32'h0000_2080);
    idle(1);
    access("R6", 1, 5, 15, 32'h8000_00c0);
    // R7 TLB window
    for (int op = 0; op <= 8; op++) access("R7", 1, 6, op, '0);
    // R8 unreadable pairs
    access("R8", 0, 5, 28, '0);
    access("R8", 0, 6, 2, '0);
    access("R8", 0, 7, 0, '0);
    access("R8", 0, 15, 0, '0);
    // R9 high index writes, then storage unchanged
    access("R9", 1, 7, 0, 32'h7777_7777);
    access("R9", 1, 15, 2, 32'h7777_7777);
    access("R9", 1, 9, 28, 32'h7777_7777);
    for (int i = 1; i <= 4; i++) access("R9", 0, i, 0, '0);
    // R10 back-to-back commands then idle
    access("R10", 1, 6, 4, '0);
    access("R10", 1, 5, 12, '0);
    idle(3);
    // R11 error on read then good access
    access("R11", 0, 3, 5, '0);
    access("R11", 0, 3, 0, '0);
    idle(3);
    if (q.size() != 0) check("R10", "queue left", 32'(q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule